// File: doc/BRIEF.md
# Dual Memory-Mapped Down-Counting Timer

This block contains two independent down-counting timers behind one simple register bus: a word address, a write strobe, write data and combinational read data. Each timer counts down from a programmed start value once per clock cycle. It either reloads and keeps running (periodic mode) or halts after its first expiry (one-shot mode). Each timer raises its own level interrupt line while its expiry flag is set and its interrupt enable is on.

Software programs a start value, then sets the enable bit in the control register to start counting. Each expiry is observed through the raw status flag, the masked status or the interrupt line. Writing a one to the raw status register acknowledges the expiry. A background-load register lets software change the value used on the next reload without disturbing the count in progress.

Top module: `twin_timer`

## Requirements
- R1: Word addresses 0 to 5 select timer 0 and 6 to 11 select timer 1. Within a bank, offset 0 is the current count, 1 the start value, 2 the background value, 3 control, 4 raw status and 5 masked status. Writes to any other address are ignored, and reads of it return zero.
- R2: Control bit 0 enables counting, bit 1 selects one-shot mode and bit 2 enables the interrupt. Only bits 2:0 are stored, and they read back zero-extended.
- R3: A control write with bit 0 set loads the count from the start value and starts counting. A control write with bit 0 clear stops the timer, and the count then holds its value.
- R4: A start-value write while the timer is enabled loads that value into the count on the same clock edge. While the timer is disabled, the write only stores the value.
- R5: A background-value write stores the value in both the background and start registers. It leaves the running count undisturbed.
- R6: While running, the count decreases by one on every clock edge. On the edge after it reads zero, the timer expires and raw status bit 0 is set, so the period is the start value plus one cycles.
- R7: On expiry in periodic mode, the count reloads from the start value and counting continues. In one-shot mode the timer stops with the count at zero.
- R8: Writing 1 to raw status bit 0 clears it, and writing 0 has no effect. An expiry in the same cycle as a clear wins, and the flag stays set.
- R9: Masked status bit 0 and the timer's interrupt output both equal raw status AND control bit 2. Both follow a register change on the clock edge that makes it.
- R10: Writes to the current count and to masked status are ignored.
- R11: While reset is low, all registers of both timers read zero, both timers are stopped and both interrupt lines are low.
- R12: The two timers are independent. An access to one bank never changes the other timer's registers, count or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; counting advances on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Word address of the register access |
| bus_we | input | 1 | Write strobe; the write takes effect on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq | output | N_TIMERS (2) | Level interrupt, one line per timer |

## Verification
The bench targets the exact expiry cycle. A counter that is one cycle off gives the wrong period and shows a stale count or flag at the sampled cycle. It drives a status clear into the very cycle of an expiry: a design where the clear wins would lose that interrupt. It also checks that a background-value write leaves the running count alone and that a start-value write with the timer disabled does not restart it. Either mistake would show up as a jump in the count. A one-shot timer is left idle after expiry to expose a design that reloads anyway. Writes to read-only, unmapped and other-bank addresses are each followed by readbacks, which would catch a decoder that aliases banks or lets a write through.

// File: rtl/twt_pkg.sv
// Package: shared register offsets and control layout for the dual timer.
// Assumes one bank of six word registers per timer.
package twt_pkg;

    localparam int REGS_PER_BANK = 6;

    typedef enum logic [2:0] {
        RIDX_COUNT  = 3'd0,
        RIDX_START  = 3'd1,
        RIDX_BACKGR = 3'd2,
        RIDX_CTRL   = 3'd3,
        RIDX_RAW    = 3'd4,
        RIDX_MASKED = 3'd5
    } reg_idx_e;

    // Control fields; run_en is the least significant bit.
    typedef struct packed {
        logic irq_en;
        logic one_shot;
        logic run_en;
    } ctrl_t;

endpackage

// File: rtl/twt_bus_decode.sv
// Module: twt_bus_decode
// Splits a word address into a one-hot timer select and a register offset.
// Assumes ADDR_W >= 3 and that N_TIMERS*REGS_PER_BANK fits in the address range.
module twt_bus_decode
    import twt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int N_TIMERS = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [N_TIMERS-1:0] sel,
    output reg_idx_e            idx
);

    // Find the bank containing the address and the offset inside it.
    always_comb begin
        logic [ADDR_W-1:0] off;
        sel = '0;
        off = '0;
        for (int t = 0; t < N_TIMERS; t++) begin
            if (addr >= ADDR_W'(t * REGS_PER_BANK) &&
                addr <  ADDR_W'((t + 1) * REGS_PER_BANK)) begin
                sel[t] = 1'b1;
                off    = addr - ADDR_W'(t * REGS_PER_BANK);
            end
        end
        idx = reg_idx_e'(off[2:0]);
    end

endmodule

// File: rtl/twt_count_core.sv
// Module: twt_count_core
// Down counter with restart, stop, periodic reload and one-shot halt.
// Assumes restart and stop are never asserted together; restart has priority.
module twt_count_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DATA_W-1:0] restart_val,
    input  logic              stop,
    input  logic              one_shot,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count,
    output logic              running,
    output logic              expire
);

    // Expiry: running at zero with no software takeover this cycle.
    assign expire = running && (count == '0) && !restart && !stop;

    // Count state: restart, stop, reload or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
        end else if (restart) begin
            count   <= restart_val;
            running <= 1'b1;
        end else if (stop) begin
            running <= 1'b0;
        end else if (running) begin
            if (count == '0) begin
                if (one_shot) begin
                    running <= 1'b0;
                end else begin
                    count <= reload_val;
                end
            end else begin
                count <= count - DATA_W'(1);
            end
        end
    end

endmodule

// File: rtl/twt_channel.sv
// Module: twt_channel
// One timer: register bank, write side effects, read mux and interrupt.
// Assumes wr_stb is already qualified by this timer's bank select.
module twt_channel
    import twt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  reg_idx_e          idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic [DATA_W-1:0] count_o,
    output logic              raw_o,
    output logic              running_o,
    output logic              one_shot_o
);

    logic [DATA_W-1:0] start_q;
    logic [DATA_W-1:0] backgr_q;
    ctrl_t             ctrl_q;
    logic              raw_q;
    logic              wr_ctrl, wr_start, wr_backgr, wr_raw;
    logic              restart, stop, expire;
    logic [DATA_W-1:0] restart_val;
    logic [DATA_W-1:0] count;
    logic              running;

    // Per-register write strobes.
    always_comb begin
        wr_ctrl   = wr_stb && (idx == RIDX_CTRL);
        wr_start  = wr_stb && (idx == RIDX_START);
        wr_backgr = wr_stb && (idx == RIDX_BACKGR);
        wr_raw    = wr_stb && (idx == RIDX_RAW);
    end

    // Counter takeover requests from software writes.
    always_comb begin
        restart     = (wr_ctrl && wdata[0]) || (wr_start && ctrl_q.run_en);
        stop        = wr_ctrl && !wdata[0];
        restart_val = wr_ctrl ? start_q : wdata;
    end

    // Value, control and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            backgr_q <= '0;
            ctrl_q   <= '0;
            raw_q    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(wdata[2:0]);
            end
            if (wr_start || wr_backgr) begin
                start_q <= wdata;
            end
            if (wr_backgr) begin
                backgr_q <= wdata;
            end
            if (expire) begin
                raw_q <= 1'b1;
            end else if (wr_raw && wdata[0]) begin
                raw_q <= 1'b0;
            end
        end
    end

    twt_count_core #(.DATA_W(DATA_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .restart_val (restart_val),
        .stop        (stop),
        .one_shot    (ctrl_q.one_shot),
        .reload_val  (start_q),
        .count       (count),
        .running     (running),
        .expire      (expire)
    );

    // Read mux over this timer's bank.
    always_comb begin
        unique case (idx)
            RIDX_COUNT:  rd_data = count;
            RIDX_START:  rd_data = start_q;
            RIDX_BACKGR: rd_data = backgr_q;
            RIDX_CTRL:   rd_data = DATA_W'(ctrl_q);
            RIDX_RAW:    rd_data = DATA_W'(raw_q);
            RIDX_MASKED: rd_data = DATA_W'(raw_q && ctrl_q.irq_en);
            default:     rd_data = '0;
        endcase
    end

    // Interrupt level and observation outputs.
    assign irq        = raw_q && ctrl_q.irq_en;
    assign count_o    = count;
    assign raw_o      = raw_q;
    assign running_o  = running;
    assign one_shot_o = ctrl_q.one_shot;

endmodule

// File: rtl/twin_timer.sv
// Module: twin_timer
// Top level: address decode, N_TIMERS timer channels, read-data merge.
// Assumes single-cycle writes and combinational reads on a word-addressed bus.
module twin_timer
    import twt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int N_TIMERS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [N_TIMERS-1:0] irq
);

    logic [N_TIMERS-1:0]             sel;
    reg_idx_e                        idx;
    logic [N_TIMERS-1:0][DATA_W-1:0] ch_rdata;
    logic [N_TIMERS-1:0][DATA_W-1:0] ch_count;
    logic [N_TIMERS-1:0]             ch_raw;
    logic [N_TIMERS-1:0]             ch_running;
    logic [N_TIMERS-1:0]             ch_one_shot;

    twt_bus_decode #(.ADDR_W(ADDR_W), .N_TIMERS(N_TIMERS)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .idx  (idx)
    );

    for (genvar t = 0; t < N_TIMERS; t++) begin : g_ch
        twt_channel #(.DATA_W(DATA_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_stb     (bus_we && sel[t]),
            .idx        (idx),
            .wdata      (bus_wdata),
            .rd_data    (ch_rdata[t]),
            .irq        (irq[t]),
            .count_o    (ch_count[t]),
            .raw_o      (ch_raw[t]),
            .running_o  (ch_running[t]),
            .one_shot_o (ch_one_shot[t])
        );
    end

    // Merge read data from the selected bank; unmapped reads give zero.
    always_comb begin
        bus_rdata = '0;
        for (int t = 0; t < N_TIMERS; t++) begin
            if (sel[t]) begin
                bus_rdata = bus_rdata | ch_rdata[t];
            end
        end
    end

endmodule

// File: rtl/twt_checker.sv
// Module: twt_checker
// Temporal checks on the dual timer, bound into twin_timer.
// Assumes the bank layout of twt_pkg.
module twt_checker
    import twt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int N_TIMERS = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic                            bus_we,
    input logic                            wbit0,
    input logic [DATA_W-1:0]               bus_rdata,
    input logic [N_TIMERS-1:0]             irq,
    input logic [N_TIMERS-1:0][DATA_W-1:0] cnt,
    input logic [N_TIMERS-1:0]             raw,
    input logic [N_TIMERS-1:0]             run,
    input logic [N_TIMERS-1:0]             one_shot
);

    // R11
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (irq == '0));

    for (genvar t = 0; t < N_TIMERS; t++) begin : g_t
        localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(t * REGS_PER_BANK + 4);
        localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(t * REGS_PER_BANK + 5);

        // R6
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            run[t] && cnt[t] != '0 && !bus_we |=> cnt[t] == $past(cnt[t]) - DATA_W'(1));

        // R6
        expiry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            run[t] && cnt[t] == '0 && !bus_we |=> raw[t]);

        // R7
        oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            run[t] && cnt[t] == '0 && one_shot[t] && !bus_we |=> !run[t]);

        // R8
        raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_we && bus_addr == A_RAW && wbit0 && !(run[t] && cnt[t] == '0) |=> !raw[t]);

        // R3
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !run[t] && !bus_we |=> $stable(cnt[t]));

        // R9
        masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_addr == A_MSK |-> bus_rdata == DATA_W'(irq[t]));
    end

endmodule

bind twin_timer twt_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .N_TIMERS (N_TIMERS)
) u_twt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .wbit0     (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .cnt       (ch_count),
    .raw       (ch_raw),
    .run       (ch_running),
    .one_shot  (ch_one_shot)
);

// File: tb/twin_timer_bench.sv
module twin_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    twin_timer u_twin_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    // Register-level vectors with both timers disabled.
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0,  32'h0,        32'h0},        // R11 count zero after reset
        '{1'b1, 4'd1,  32'h12345678, 32'h0},        // R4 start write while disabled
        '{1'b0, 4'd1,  32'h0,        32'h12345678}, // R1 start readback
        '{1'b0, 4'd2,  32'h0,        32'h0},        // R5 background untouched by start write
        '{1'b1, 4'd2,  32'h0000A5A5, 32'h0},        // R5 background write
        '{1'b0, 4'd2,  32'h0,        32'h0000A5A5}, // R5 background readback
        '{1'b0, 4'd1,  32'h0,        32'h0000A5A5}, // R5 start follows background
        '{1'b0, 4'd0,  32'h0,        32'h0},        // R4 no restart while disabled
        '{1'b1, 4'd0,  32'h0000FFFF, 32'h0},        // R10 write to count
        '{1'b0, 4'd0,  32'h0,        32'h0},        // R10 count unchanged
        '{1'b1, 4'd3,  32'hFFFFFFFE, 32'h0},        // R2 control write, enable clear
        '{1'b0, 4'd3,  32'h0,        32'h6},        // R2 only bits 2:0 kept
        '{1'b1, 4'd5,  32'h1,        32'h0},        // R10 write to masked status
        '{1'b0, 4'd5,  32'h0,        32'h0},        // R10 masked still zero
        '{1'b1, 4'd7,  32'h77,       32'h0},        // R1 timer 1 start write
        '{1'b0, 4'd7,  32'h0,        32'h77},       // R1 timer 1 start readback
        '{1'b0, 4'd1,  32'h0,        32'h0000A5A5}, // R12 timer 0 untouched
        '{1'b1, 4'd12, 32'hDEAD,     32'h0},        // R1 unmapped write
        '{1'b0, 4'd12, 32'h0,        32'h0},        // R1 unmapped reads zero
        '{1'b0, 4'd15, 32'h0,        32'h0},        // R1 top address reads zero
        '{1'b0, 4'd6,  32'h0,        32'h0}         // R12 timer 1 count idle
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    logic [31:0] v;

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 irq in reset", 32'(irq), 32'h0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) begin
                wr(VECS[i].a, VECS[i].d);
            end else begin
                rd(VECS[i].a, v);
                check($sformatf("R1/R2/R4/R5/R10/R12 vector %0d", i), v, VECS[i].e);
            end
        end
        wr(4'd3, 32'h0);

        // R3 R6 R7 periodic counting on timer 0, start value 5.
        wr(4'd2, 32'd5);
        wr(4'd3, 32'h1);
        rd(4'd0, v); check("R3 enable loads start", v, 32'd5);
        edges(5);
        rd(4'd0, v); check("R6 count at zero", v, 32'd0);
        rd(4'd4, v); check("R6 no flag before expiry", v, 32'd0);
        edges(1);
        rd(4'd4, v); check("R6 flag at expiry", v, 32'd1);
        rd(4'd0, v); check("R7 periodic reload", v, 32'd5);
        check("R9 irq off without enable", 32'(irq), 32'h0);
        rd(4'd5, v); check("R9 masked off without enable", v, 32'd0);

        // R9 interrupt enable, R8 clear behaviour.
        wr(4'd3, 32'h5);
        check("R9 irq follows enable", 32'(irq), 32'h1);
        rd(4'd5, v); check("R9 masked follows enable", v, 32'd1);
        wr(4'd4, 32'h0);
        rd(4'd4, v); check("R8 zero write keeps flag", v, 32'd1);
        wr(4'd4, 32'h1);
        rd(4'd4, v); check("R8 one write clears flag", v, 32'd0);
        check("R9 irq drops on clear", 32'(irq), 32'h0);

        // R4 start write while enabled restarts; R5 background does not.
        wr(4'd1, 32'd100);
        rd(4'd0, v); check("R4 enabled start write restarts", v, 32'd100);
        wr(4'd2, 32'd50);
        rd(4'd0, v); check("R5 background keeps count", v, 32'd99);
        rd(4'd1, v); check("R5 background sets start", v, 32'd50);

        // R3 stop holds; R4 disabled start write does not restart.
        wr(4'd3, 32'h0);
        rd(4'd0, v); check("R3 stop holds count", v, 32'd99);
        wr(4'd1, 32'd7);
        edges(3);
        rd(4'd0, v); check("R4 disabled start write no restart", v, 32'd99);

        // R8 clear in the expiry cycle: expiry wins.
        wr(4'd2, 32'd3);
        wr(4'd3, 32'h1);
        edges(3);
        wr(4'd4, 32'h1);
        rd(4'd4, v); check("R8 expiry beats clear", v, 32'd1);
        rd(4'd0, v); check("R7 reload after race", v, 32'd3);

        // R7 one-shot on timer 1; R12 independence.
        wr(4'd7, 32'd2);
        wr(4'd9, 32'h3);
        edges(3);
        rd(4'd10, v); check("R7 one-shot expiry flag", v, 32'd1);
        rd(4'd6, v);  check("R7 one-shot count zero", v, 32'd0);
        edges(4);
        rd(4'd6, v);  check("R7 one-shot stays stopped", v, 32'd0);
        check("R12 timer 1 irq off", 32'(irq[1]), 32'h0);
        wr(4'd9, 32'h6);
        check("R9 timer 1 irq on enable", 32'(irq[1]), 32'h1);
        rd(4'd11, v); check("R9 timer 1 masked", v, 32'd1);
        rd(4'd3, v);  check("R12 timer 0 control intact", v, 32'd1);
        check("R12 timer 0 irq unaffected", 32'(irq[0]), 32'h0);

        // R11 reset clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        edges(2);
        check("R11 irq cleared", 32'(irq), 32'h0);
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            check($sformatf("R11 register %0d cleared", a), v, 32'd0);
        end
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule